// File: doc/BRIEF.md
# Two-Dialect Parallel Flash Bank Eraser and Programmer

This block runs a complete erase or program job on one bank of an 8-bit asynchronous parallel flash, with no processor help once the job starts. A single input picks which command dialect the attached device uses. In the status dialect the block writes command bytes to the bank base and polls a status register until its ready bit is set. In the unlock dialect every operation starts with a two-write unlock pair at fixed offsets, and completion is seen when two reads of the bank base in a row return the same byte.

A job is started with a one-cycle pulse on `start`. The block sends the command writes, and for a program job it sends one byte at a time from a source buffer. It bounds every poll, sends the dialect's exit commands, and then reads the whole bank back. An erase must read back as all 0xFF. A program must match the source buffer. At the end the block pulses `done`, and sticky error flags report a poll timeout, a device status error or a verify mismatch. Every flash access holds its strobe for a set number of cycles, and the block leaves a set idle time after each access so that the device's minimum spacing between commands is met.

Top module: `flash_bank_prog`

## Requirements
- R1: After reset `busy`, `done`, all error flags, `fl_we` and `fl_re` are low.
- R2: Status-dialect erase writes 0x20 then 0xD0 to offset 0. Each poll attempt writes 0x70 to offset 0 and then reads offset 0, and completion is bit 7 of that read being 1. The job then writes 0x50 and then 0xFF to offset 0.
- R3: Status-dialect program, for each byte index i from 0 up to the last bank byte: write 0x40 to offset i, write the source byte to offset i, then poll as in R2. The job closes with 0x50 and then 0xFF to offset 0.
- R4: Unlock-dialect erase writes AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, 30@0. It then polls and finishes with a single F0@0.
- R5: Unlock-dialect program, for each byte i: AA@0x555, 55@0x2AA, A0@0x555, then the source byte at offset i. One poll attempt is two reads of offset 0, and the attempt succeeds when both reads are equal. The job finishes with F0@0.
- R6: Each strobe stays high for exactly ACC_CYC cycles. At least GAP_CYC low cycles separate two strobes, and the write and read strobes are never high together.
- R7: After POLL_MAX failed attempts the block sets `err_timeout`, starts no further byte, still sends the exit commands and then verifies. A new start clears all error flags.
- R8: The verify pass reads every bank byte from offset 0 upward. It expects 0xFF after an erase and the source byte after a program. The first mismatch sets `err_verify` and ends the job.
- R9: In the status dialect, if a poll read that shows ready also has any of bits 5, 4 or 3 (mask 0x38) set, `err_status` is set.
- R10: `busy` rises the cycle after an accepted start. `done` is a single-cycle pulse given with `busy` low. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle job request |
| op_program | input | 1 | 1 = program from source, 0 = erase |
| dialect_unlock | input | 1 | 1 = unlock/toggle dialect, 0 = status-register dialect |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err_timeout | output | 1 | A poll ran out of attempts |
| err_status | output | 1 | Device reported an error in status bits 0x38 |
| err_verify | output | 1 | Readback mismatch |
| src_addr | output | BANK_W | Source buffer byte index |
| src_data | input | 8 | Source byte, valid one cycle after `src_addr` |
| fl_addr | output | FADDR_W | Flash byte offset |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |

## Verification
The bench builds the block with a 16-byte bank (BANK_W=4) inside a 12-bit flash offset space. That still holds the 0x555 and 0x2AA unlock offsets, and it keeps a full program-and-verify pass short. ACC_CYC=2 and GAP_CYC=3 keep the strobe length and the spacing between accesses distinct, so an off-by-one in either one shows up. POLL_MAX=6 lets a device model that never finishes drive both dialects into timeout. In that case the block must stop after the first byte and still send its exit commands.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CMD,
    SQ_POLL_A,
    SQ_POLL_B,
    SQ_FIN,
    SQ_VER,
    SQ_DONE
  } seq_state_t;

  // status-register dialect
  localparam logic [7:0] SD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] SD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] SD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] SD_READ_STAT   = 8'h70;
  localparam logic [7:0] SD_CLR_STAT    = 8'h50;
  localparam logic [7:0] SD_RESET       = 8'hFF;
  localparam int         SD_READY_BIT   = 7;
  localparam logic [7:0] SD_FAULT_MASK  = 8'h38;

  // unlock/toggle dialect
  localparam logic [7:0] UD_KEY1        = 8'hAA;
  localparam logic [7:0] UD_KEY2        = 8'h55;
  localparam logic [7:0] UD_ERASE_ARM   = 8'h80;
  localparam logic [7:0] UD_ERASE_GO    = 8'h30;
  localparam logic [7:0] UD_PROG_ARM    = 8'hA0;
  localparam logic [7:0] UD_RESET       = 8'hF0;
  localparam int         UD_KEY1_OFS    = 'h555;
  localparam int         UD_KEY2_OFS    = 'h2AA;

  localparam logic [7:0] ERASED_BYTE    = 8'hFF;

endpackage

// File: rtl/flash_cmd_script.sv
module flash_cmd_script
  import flash_prog_pkg::*;
#(
  parameter int FADDR_W = 13,
  parameter int BANK_W  = 13
) (
  input  logic               unlock_mode,
  input  logic               prog_mode,
  input  logic               fin_phase,
  input  logic [2:0]         step,
  input  logic [BANK_W-1:0]  idx,
  input  logic [7:0]         src_byte,
  output logic [FADDR_W-1:0] addr,
  output logic [7:0]         data,
  output logic               last
);
  localparam logic [FADDR_W-1:0] K1_A = FADDR_W'(UD_KEY1_OFS);
  localparam logic [FADDR_W-1:0] K2_A = FADDR_W'(UD_KEY2_OFS);

  logic [FADDR_W-1:0] tgt;
  assign tgt = FADDR_W'(idx);

  always_comb begin
    addr = '0;
    data = UD_RESET;
    last = 1'b1;
    if (fin_phase) begin
      if (!unlock_mode) begin
        data = (step == 3'd0) ? SD_CLR_STAT : SD_RESET;
        last = (step != 3'd0);
      end
    end else if (unlock_mode) begin
      if (prog_mode) begin
        case (step)
          3'd0:    begin addr = K1_A; data = UD_KEY1;     last = 1'b0; end
          3'd1:    begin addr = K2_A; data = UD_KEY2;     last = 1'b0; end
          3'd2:    begin addr = K1_A; data = UD_PROG_ARM; last = 1'b0; end
          default: begin addr = tgt;  data = src_byte;    last = 1'b1; end
        endcase
      end else begin
        case (step)
          3'd0:    begin addr = K1_A; data = UD_KEY1;      last = 1'b0; end
          3'd1:    begin addr = K2_A; data = UD_KEY2;      last = 1'b0; end
          3'd2:    begin addr = K1_A; data = UD_ERASE_ARM; last = 1'b0; end
          3'd3:    begin addr = K1_A; data = UD_KEY1;      last = 1'b0; end
          3'd4:    begin addr = K2_A; data = UD_KEY2;      last = 1'b0; end
          default: begin addr = '0;   data = UD_ERASE_GO;  last = 1'b1; end
        endcase
      end
    end else begin
      if (prog_mode) begin
        addr = tgt;
        data = (step == 3'd0) ? SD_PROG_SETUP : src_byte;
        last = (step != 3'd0);
      end else begin
        data = (step == 3'd0) ? SD_ERASE_SETUP : SD_ERASE_GO;
        last = (step != 3'd0);
      end
    end
  end
endmodule

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int FADDR_W = 13,
  parameter int ACC_CYC = 4,
  parameter int GAP_CYC = 250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               req_wr,
  input  logic [FADDR_W-1:0] req_addr,
  input  logic [7:0]         req_wdata,
  output logic               ack,
  output logic [7:0]         rd_byte,
  output logic [FADDR_W-1:0] fl_addr,
  output logic [7:0]         fl_wdata,
  input  logic [7:0]         fl_rdata,
  output logic               fl_we,
  output logic               fl_re
);
  localparam int CNT_TOP = (ACC_CYC > GAP_CYC) ? ACC_CYC : GAP_CYC;
  localparam int CW      = $clog2(CNT_TOP + 1);

  typedef enum logic [1:0] {BP_IDLE, BP_ACC, BP_GAP} bp_state_t;
  bp_state_t       st;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BP_IDLE;
      cnt      <= '0;
      ack      <= 1'b0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      rd_byte  <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        BP_IDLE: if (req) begin
          fl_addr  <= req_addr;
          fl_wdata <= req_wdata;
          fl_we    <= req_wr;
          fl_re    <= !req_wr;
          cnt      <= CW'(ACC_CYC - 1);
          st       <= BP_ACC;
        end
        BP_ACC: if (cnt == '0) begin
          fl_we <= 1'b0;
          fl_re <= 1'b0;
          if (fl_re) rd_byte <= fl_rdata;
          if (GAP_CYC == 0) begin
            ack <= 1'b1;
            st  <= BP_IDLE;
          end else begin
            cnt <= CW'(GAP_CYC - 1);
            st  <= BP_GAP;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        BP_GAP: if (cnt == '0) begin
          ack <= 1'b1;
          st  <= BP_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= BP_IDLE;
      endcase
    end
  end

  // strobe-shape checking counters
  logic [31:0] hi_len, lo_len;
  logic        seen_acc;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len   <= '0;
      lo_len   <= '0;
      seen_acc <= 1'b0;
    end else if (fl_we || fl_re) begin
      hi_len   <= hi_len + 1;
      lo_len   <= '0;
      seen_acc <= 1'b1;
    end else begin
      hi_len <= '0;
      if (lo_len != 32'hFFFF_FFFF) lo_len <= lo_len + 1;
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));
  assert_strobe_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we || fl_re) |-> (hi_len == 32'(ACC_CYC)));
  assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(fl_we || fl_re) && seen_acc) |-> (lo_len >= 32'(GAP_CYC)));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_prog_pkg::*;
#(
  parameter int FADDR_W  = 13,
  parameter int BANK_W   = 13,
  parameter int POLL_MAX = 1000000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               op_program,
  input  logic               dialect_unlock,
  output logic               busy,
  output logic               done,
  output logic               err_timeout,
  output logic               err_status,
  output logic               err_verify,
  output logic [BANK_W-1:0]  src_addr,
  input  logic [7:0]         src_data,
  output logic               scr_unlock,
  output logic               scr_prog,
  output logic               scr_fin,
  output logic [2:0]         scr_step,
  input  logic [FADDR_W-1:0] scr_addr,
  input  logic [7:0]         scr_data,
  input  logic               scr_last,
  output logic               req,
  output logic               req_wr,
  output logic [FADDR_W-1:0] req_addr,
  output logic [7:0]         req_wdata,
  input  logic               ack,
  input  logic [7:0]         rd_byte
);
  localparam int               PW       = $clog2(POLL_MAX + 1);
  localparam logic [BANK_W-1:0] IDX_LAST = '1;

  seq_state_t        st;
  logic              pend;
  logic [BANK_W-1:0] idx;
  logic [2:0]        step;
  logic [PW-1:0]     pcnt;
  logic [7:0]        prev;
  logic              mode_u, mode_p;
  logic              poll_ok;
  logic [7:0]        ver_exp;

  assign src_addr   = idx;
  assign scr_unlock = mode_u;
  assign scr_prog   = mode_p;
  assign scr_fin    = (st == SQ_FIN);
  assign scr_step   = step;

  always_comb begin
    poll_ok = mode_u ? (rd_byte == prev) : rd_byte[SD_READY_BIT];
    ver_exp = mode_p ? src_data : ERASED_BYTE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      pend        <= 1'b0;
      idx         <= '0;
      step        <= '0;
      pcnt        <= '0;
      prev        <= '0;
      mode_u      <= 1'b0;
      mode_p      <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_status  <= 1'b0;
      err_verify  <= 1'b0;
      req         <= 1'b0;
      req_wr      <= 1'b0;
      req_addr    <= '0;
      req_wdata   <= '0;
    end else begin
      req  <= 1'b0;
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          mode_u      <= dialect_unlock;
          mode_p      <= op_program;
          idx         <= '0;
          step        <= '0;
          pend        <= 1'b0;
          err_timeout <= 1'b0;
          err_status  <= 1'b0;
          err_verify  <= 1'b0;
          busy        <= 1'b1;
          st          <= SQ_CMD;
        end
        SQ_CMD, SQ_FIN: begin
          if (!pend) begin
            req       <= 1'b1;
            req_wr    <= 1'b1;
            req_addr  <= scr_addr;
            req_wdata <= scr_data;
            pend      <= 1'b1;
          end else if (ack) begin
            pend <= 1'b0;
            if (scr_last) begin
              step <= '0;
              if (st == SQ_CMD) begin
                pcnt <= '0;
                st   <= SQ_POLL_A;
              end else begin
                idx <= '0;
                st  <= SQ_VER;
              end
            end else begin
              step <= step + 3'd1;
            end
          end
        end
        SQ_POLL_A: begin
          if (!pend) begin
            req       <= 1'b1;
            req_wr    <= !mode_u;
            req_addr  <= '0;
            req_wdata <= SD_READ_STAT;
            pend      <= 1'b1;
          end else if (ack) begin
            pend <= 1'b0;
            prev <= rd_byte;
            st   <= SQ_POLL_B;
          end
        end
        SQ_POLL_B: begin
          if (!pend) begin
            req      <= 1'b1;
            req_wr   <= 1'b0;
            req_addr <= '0;
            pend     <= 1'b1;
          end else if (ack) begin
            pend <= 1'b0;
            step <= '0;
            if (poll_ok) begin
              if (!mode_u && |(rd_byte & SD_FAULT_MASK)) err_status <= 1'b1;
              if (mode_p && idx != IDX_LAST) begin
                idx <= idx + 1'b1;
                st  <= SQ_CMD;
              end else begin
                st <= SQ_FIN;
              end
            end else if (pcnt == PW'(POLL_MAX - 1)) begin
              err_timeout <= 1'b1;
              st          <= SQ_FIN;
            end else begin
              pcnt <= pcnt + 1'b1;
              st   <= SQ_POLL_A;
            end
          end
        end
        SQ_VER: begin
          if (!pend) begin
            req      <= 1'b1;
            req_wr   <= 1'b0;
            req_addr <= FADDR_W'(idx);
            pend     <= 1'b1;
          end else if (ack) begin
            pend <= 1'b0;
            if (rd_byte != ver_exp) begin
              err_verify <= 1'b1;
              st         <= SQ_DONE;
            end else if (idx == IDX_LAST) begin
              st <= SQ_DONE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        SQ_DONE: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_no_byte_after_timeout_R7: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_CMD) |-> !err_timeout);
  assert_mismatch_in_verify_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_verify) |-> ($past(st) == SQ_VER));
  assert_status_dialect_only_R9: assert property (@(posedge clk) disable iff (rst)
    err_status |-> !mode_u);
endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog #(
  parameter int FADDR_W  = 13,
  parameter int BANK_W   = 13,
  parameter int ACC_CYC  = 4,
  parameter int GAP_CYC  = 250,
  parameter int POLL_MAX = 1000000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               op_program,
  input  logic               dialect_unlock,
  output logic               busy,
  output logic               done,
  output logic               err_timeout,
  output logic               err_status,
  output logic               err_verify,
  output logic [BANK_W-1:0]  src_addr,
  input  logic [7:0]         src_data,
  output logic [FADDR_W-1:0] fl_addr,
  output logic [7:0]         fl_wdata,
  input  logic [7:0]         fl_rdata,
  output logic               fl_we,
  output logic               fl_re
);
  logic               scr_unlock, scr_prog, scr_fin, scr_last;
  logic [2:0]         scr_step;
  logic [FADDR_W-1:0] scr_addr;
  logic [7:0]         scr_data;
  logic               req, req_wr, ack;
  logic [FADDR_W-1:0] req_addr;
  logic [7:0]         req_wdata, rd_byte;

  flash_seq #(.FADDR_W(FADDR_W), .BANK_W(BANK_W), .POLL_MAX(POLL_MAX)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op_program(op_program),
    .dialect_unlock(dialect_unlock), .busy(busy), .done(done),
    .err_timeout(err_timeout), .err_status(err_status), .err_verify(err_verify),
    .src_addr(src_addr), .src_data(src_data),
    .scr_unlock(scr_unlock), .scr_prog(scr_prog), .scr_fin(scr_fin),
    .scr_step(scr_step), .scr_addr(scr_addr), .scr_data(scr_data),
    .scr_last(scr_last), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_byte(rd_byte)
  );

  flash_cmd_script #(.FADDR_W(FADDR_W), .BANK_W(BANK_W)) u_script (
    .unlock_mode(scr_unlock), .prog_mode(scr_prog), .fin_phase(scr_fin),
    .step(scr_step), .idx(src_addr), .src_byte(src_data),
    .addr(scr_addr), .data(scr_data), .last(scr_last)
  );

  flash_bus_port #(.FADDR_W(FADDR_W), .ACC_CYC(ACC_CYC), .GAP_CYC(GAP_CYC)) u_port (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_byte(rd_byte),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_we(fl_we), .fl_re(fl_re)
  );
endmodule

// File: tb/flash_bank_prog_test.sv
`timescale 1ns/1ps
module flash_bank_prog_test;
  localparam int FW = 12, BW = 4, ACC = 2, GAP = 3, PM = 6;
  localparam int NB = 1 << BW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, op_program = 1'b0, dialect_unlock = 1'b0;
  logic busy, done, err_timeout, err_status, err_verify, fl_we, fl_re;
  logic [BW-1:0] src_addr;
  logic [7:0]    src_data, fl_wdata, fl_rdata;
  logic [FW-1:0] fl_addr;

  always #2 clk = ~clk;

  flash_bank_prog #(.FADDR_W(FW), .BANK_W(BW), .ACC_CYC(ACC), .GAP_CYC(GAP), .POLL_MAX(PM)) uut (
    .clk(clk), .rst(rst), .start(start), .op_program(op_program),
    .dialect_unlock(dialect_unlock), .busy(busy), .done(done),
    .err_timeout(err_timeout), .err_status(err_status), .err_verify(err_verify),
    .src_addr(src_addr), .src_data(src_data), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re)
  );

  int checks = 0, errors = 0, dones = 0, tviol = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  // source buffer, one-cycle read latency
  logic [7:0] src [NB];
  always @(posedge clk) src_data <= src[src_addr];

  // flash model knobs and state
  bit         mdl_u;
  int         busy_knob, busy_left, bad_idx;
  logic [7:0] fault_bits, rd_q, tog;
  logic [7:0] fmem [NB];
  bit         p_arm, e_arm, stat_mode, we_d, re_d;
  int         hi, lo;
  bit         seen;
  assign fl_rdata = rd_q;

  // expected write scoreboard
  logic [FW+7:0] expq[$];
  task automatic push(input int a, input int d);
    expq.push_back({FW'(a), 8'(d)});
  endtask

  always @(negedge clk) begin
    if (done) dones++;
    if (fl_we && !we_d) begin
      logic [FW+7:0] e;
      int i;
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s extra write act=%h exp=none", cur_req, {fl_addr, fl_wdata});
      end else begin
        e = expq.pop_front();
        if (e != {fl_addr, fl_wdata}) begin
          errors++;
          $display("FAIL %s write act=%h exp=%h", cur_req, {fl_addr, fl_wdata}, e);
        end
      end
      i = int'(fl_addr[BW-1:0]);
      if (p_arm) begin
        fmem[i] = (i == bad_idx) ? (fl_wdata ^ 8'h01) : fl_wdata;
        p_arm = 0; stat_mode = 0; busy_left = busy_knob;
      end else begin
        stat_mode = !mdl_u && (fl_wdata == 8'h70);
        if (!mdl_u) begin
          if (fl_wdata == 8'h40) p_arm = 1;
          if (e_arm && fl_wdata == 8'hD0) begin
            for (int k = 0; k < NB; k++) fmem[k] = 8'hFF;
            busy_left = busy_knob;
          end
          e_arm = (fl_wdata == 8'h20);
        end else begin
          if (fl_wdata == 8'hA0) p_arm = 1;
          if (fl_wdata == 8'h80) e_arm = 1;
          if (fl_wdata == 8'hF0) e_arm = 0;
          if (e_arm && fl_wdata == 8'h30) begin
            for (int k = 0; k < NB; k++) fmem[k] = 8'hFF;
            e_arm = 0; busy_left = busy_knob;
          end
        end
      end
    end
    if (fl_re && !re_d) begin
      if (!mdl_u && stat_mode) begin
        if (busy_left > 0) begin rd_q = 8'h00; busy_left--; end
        else rd_q = 8'h80 | fault_bits;
      end else if (mdl_u && busy_left > 0) begin
        tog = tog ^ 8'h40; rd_q = tog; busy_left--;
      end else begin
        rd_q = fmem[fl_addr[BW-1:0]];
      end
    end
    // R6 strobe shape, measured at the pins
    if (fl_we && fl_re) tviol++;
    if (fl_we || fl_re) begin
      if (!(we_d || re_d) && seen && lo < GAP) tviol++;
      hi++; lo = 0; seen = 1;
    end else begin
      if (we_d || re_d) begin if (hi != ACC) tviol++; end
      hi = 0; lo++;
    end
    we_d = fl_we; re_d = fl_re;
  end

  task automatic expect_job(input bit u, input bit p, input int b, input bit to);
    int polls, nbytes;
    polls  = to ? PM : b + 1;
    nbytes = p ? (to ? 1 : NB) : 1;
    for (int i = 0; i < nbytes; i++) begin
      if (u) begin
        push('h555, 'hAA); push('h2AA, 'h55);
        if (p) begin push('h555, 'hA0); push(i, src[i]); end
        else begin push('h555, 'h80); push('h555, 'hAA); push('h2AA, 'h55); push(0, 'h30); end
      end else begin
        if (p) begin push(i, 'h40); push(i, src[i]); end
        else begin push(0, 'h20); push(0, 'hD0); end
        for (int k = 0; k < polls; k++) push(0, 'h70);
      end
    end
    if (u) push(0, 'hF0);
    else begin push(0, 'h50); push(0, 'hFF); end
  endtask

  task automatic run_job(input bit u, input bit p, input int b, input bit to,
                         input bit poke, input string r);
    int d0;
    cur_req = r; mdl_u = u; busy_knob = b; busy_left = 0;
    p_arm = 0; e_arm = 0; stat_mode = 0;
    expect_job(u, p, b, to);
    d0 = dones;
    @(negedge clk);
    start = 1; op_program = p; dialect_unlock = u;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; op_program = !p; dialect_unlock = !u;
      @(negedge clk);
      start = 0; op_program = p; dialect_unlock = u;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(expq.size() == 0, r, "expected writes left", expq.size(), 0);
    expq.delete();
    chk(dones - d0 == 1, "R10", "done pulses per job", dones - d0, 1);
  endtask

  task automatic chk_mem(input bit prog, input string r);
    int bad;
    bad = 0;
    for (int i = 0; i < NB; i++)
      if (fmem[i] != (prog ? src[i] : 8'hFF)) bad++;
    chk(bad == 0, r, "flash content mismatches", bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bad_idx = -1; fault_bits = 8'h00; tog = 8'h2A; rd_q = 8'h00;
    for (int i = 0; i < NB; i++) begin src[i] = 8'(8'h11 * i) ^ 8'h5C; fmem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    chk({err_timeout, err_status, err_verify} == 0, "R1", "error flags in reset",
        {err_timeout, err_status, err_verify}, 0);
    chk(fl_we == 0 && fl_re == 0, "R1", "strobes in reset", {fl_we, fl_re}, 0);
    rst = 0;

    // R2 status erase, two busy polls
    run_job(0, 0, 2, 0, 0, "R2");
    chk({err_timeout, err_status, err_verify} == 0, "R2", "flags after erase",
        {err_timeout, err_status, err_verify}, 0);
    chk_mem(0, "R8");

    // R3 status program
    run_job(0, 1, 1, 0, 0, "R3");
    chk(err_verify == 0, "R8", "verify flag after good program", err_verify, 0);
    chk_mem(1, "R3");

    // R9 status fault bits
    fault_bits = 8'h10;
    run_job(0, 1, 0, 0, 0, "R9");
    chk(err_status == 1, "R9", "status fault flag", err_status, 1);
    fault_bits = 8'h00;

    // R4 unlock erase
    run_job(1, 0, 3, 0, 0, "R4");
    chk({err_timeout, err_status, err_verify} == 0, "R4", "flags after unlock erase",
        {err_timeout, err_status, err_verify}, 0);
    chk_mem(0, "R4");

    // R5 unlock program, new pattern, start poked while busy (R10)
    for (int i = 0; i < NB; i++) src[i] = 8'(i * 37 + 1);
    run_job(1, 1, 2, 0, 1, "R5");
    chk(err_verify == 0 && err_timeout == 0, "R5", "flags after unlock program",
        {err_timeout, err_verify}, 0);
    chk_mem(1, "R5");

    // R8 verify catches a corrupted byte
    bad_idx = 5;
    run_job(1, 1, 1, 0, 0, "R8");
    chk(err_verify == 1, "R8", "mismatch flag", err_verify, 1);
    bad_idx = -1;

    // R7 status program timeout stops after byte 0
    run_job(0, 0, 0, 0, 0, "R2");
    run_job(0, 1, 100, 1, 0, "R7");
    chk(err_timeout == 1, "R7", "timeout flag status dialect", err_timeout, 1);
    chk(err_verify == 1, "R8", "verify after partial program", err_verify, 1);

    // R7 unlock erase timeout
    run_job(1, 0, 100, 1, 0, "R7");
    chk(err_timeout == 1, "R7", "timeout flag unlock dialect", err_timeout, 1);

    // R7 flags cleared by a new start
    run_job(0, 0, 0, 0, 0, "R7");
    chk({err_timeout, err_verify} == 0, "R7", "flags cleared on new job",
        {err_timeout, err_verify}, 0);

    chk(tviol == 0, "R6", "strobe length/gap violations", tviol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule